// File: doc/BRIEF.md
# Command Queue Thread Sequencer

This block is a single execution thread of a command-queue engine. Software loads a start address and a stop address into a small register window and sets the enable bit. The thread then fetches 64-bit instructions one at a time over a simple read request/response port. It follows jumps, blocks on an event input when told to wait, and raises a done or error interrupt. Instructions that would move data are executed as no-ops.

Addresses in the program-counter and end registers are kept in shifted form. The byte address on the memory port equals the stored value shifted left by the parameter `SHIFT`, which is 0 or 3. One instruction therefore advances the stored address by `8 >> SHIFT`.

The register window also supports three control actions. A self-clearing warm reset clears the thread. A suspend handshake reports when the thread has actually stopped. A write to the program counter, including a write of its present value, discards any fetch that is still in flight and restarts fetching there. Register reads return data one cycle after the address is presented.

Top module: `cq_thread`

## Requirements
- R1: After the synchronous reset, every register in the window reads 0, `mem_req` is low and `irq` is low.
- R2: Writing 1 to bit 0 of the warm-reset word (offset 0x00) makes that bit read back 1 on the next read. The bit clears by itself once no fetch is outstanding. Completion zeroes the program counter, end address, priority (0x40), interrupt enable, suspend and enable, and leaves interrupt status untouched.
- R3: Each fetch presents the byte address `pc << SHIFT` on `mem_addr` with a one-cycle `mem_req` pulse. At most one fetch is outstanding at a time. A no-op instruction (top byte 0x40) advances the program counter by one instruction, which is 8 bytes.
- R4: When an enabled thread's program counter (0x20) equals its end address (0x24), the thread sets interrupt status bit 0 (done). It also clears enable (0x04, bit 0) and issues no further fetch.
- R5: An instruction whose upper 32 bits are 0x10000001 loads its lower 32 bits into the program counter as a shifted address.
- R6: An instruction whose upper 32 bits are 0x10000000 adds its lower 32 bits (in shifted units, modulo 2^32) to the program counter.
- R7: A fault sets interrupt status bit 4 and halts the thread. A fault is any instruction whose top byte is not 0x20 or 0x40 and that is not one of the two jump words, or any jump whose target is at or above `LIMIT`. After a fault the program counter stays on the faulting instruction and enable stays 1. No fetch is issued until the program counter is written.
- R8: Writing 1 to the suspend word (0x08) stops new fetches. Bit 1 of the status word (0x0C) reads 1 once no fetch is outstanding. Writing 0 resumes execution.
- R9: Writing the program counter discards any outstanding fetch response and restarts fetching at the written address. This also holds when the written value equals the present one.
- R10: An instruction with top byte 0x20 blocks the thread while `evt_in` is low. During that time bit 31 of the wait word (0x30) reads 1. The thread moves on to the next instruction once `evt_in` is high.
- R11: A write to interrupt status (0x10) clears each flag whose written bit is 0 and keeps each flag whose written bit is 1. Interrupt enable (0x14) holds bits 0, 1 and 4. `irq` is registered and equals the OR of status AND enable, one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | RAW | Register byte offset in the window |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for the offset presented in the previous cycle |
| mem_req | output | 1 | One-cycle fetch request pulse |
| mem_addr | output | 32 | Fetch byte address |
| mem_rvalid | input | 1 | Fetch response valid |
| mem_rdata | input | 64 | Fetched instruction |
| evt_in | input | 1 | Event flag released by a wait instruction |
| irq | output | 1 | Interrupt request |

## Verification
Several properties are checked on every cycle. A fetch may start only when none is outstanding. No fetch may start in the cycle after suspend was set, and none while the thread is halted. A rising done flag must come with enable already cleared. The end of a warm reset must leave the control registers zero. `irq` must track status and enable with one cycle of lag. Other behaviour shows only in the bench's programs. These include the exact fetch address sequence, jump targets and wrap-around, the exact bound of the jump limit, and the discarding of a stale response after a program-counter rewrite, which is seen through fetch counts. They also include the point where a wait releases, the read-back of the warm-reset bit, and the write-zero-to-clear rule.

// File: rtl/cq_pkg.sv
package cq_pkg;
  localparam logic [7:0] OFF_WRST = 8'h00;
  localparam logic [7:0] OFF_EN   = 8'h04;
  localparam logic [7:0] OFF_SUSP = 8'h08;
  localparam logic [7:0] OFF_STAT = 8'h0C;
  localparam logic [7:0] OFF_ISTS = 8'h10;
  localparam logic [7:0] OFF_IEN  = 8'h14;
  localparam logic [7:0] OFF_PC   = 8'h20;
  localparam logic [7:0] OFF_END  = 8'h24;
  localparam logic [7:0] OFF_WTOK = 8'h30;
  localparam logic [7:0] OFF_PRIO = 8'h40;

  localparam logic [31:0] JMP_ABS = 32'h1000_0001;
  localparam logic [31:0] JMP_REL = 32'h1000_0000;
  localparam logic [7:0]  OP_WAIT = 8'h20;
  localparam logic [7:0]  OP_NOP  = 8'h40;

  localparam logic [31:0] IRQ_MASK = 32'h0000_0013;

  typedef enum logic [1:0] {K_NOP, K_WAIT, K_JUMP, K_BAD} kind_e;
endpackage

// File: rtl/cq_decode.sv
module cq_decode
  import cq_pkg::*;
#(
  parameter logic [31:0] LIMIT = 32'h100
) (
  input  logic [63:0] instr,
  input  logic [31:0] pc,
  output kind_e       kind,
  output logic [31:0] target
);
  logic [31:0] hi, lo;
  assign hi = instr[63:32];
  assign lo = instr[31:0];

  always_comb begin
    target = pc;
    kind   = K_BAD;
    if (hi == JMP_ABS || hi == JMP_REL) begin
      target = (hi == JMP_ABS) ? lo : pc + lo;
      kind   = (target >= LIMIT) ? K_BAD : K_JUMP;
    end else if (instr[63:56] == OP_WAIT) begin
      kind = K_WAIT;
    end else if (instr[63:56] == OP_NOP) begin
      kind = K_NOP;
    end
  end
endmodule

// File: rtl/cq_fetch.sv
module cq_fetch #(
  parameter int SHIFT = 3
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        issue,
  input  logic [31:0] pc,
  input  logic        flush,
  input  logic        mem_rvalid,
  output logic        mem_req,
  output logic [31:0] mem_addr,
  output logic        busy,
  output logic        rsp_ok
);
  logic disc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req  <= 1'b0;
      mem_addr <= '0;
      busy     <= 1'b0;
      disc_q   <= 1'b0;
    end else begin
      mem_req <= issue;
      if (issue) mem_addr <= pc << SHIFT;
      if (issue) busy <= 1'b1;
      else if (mem_rvalid) busy <= 1'b0;
      if (mem_rvalid) disc_q <= 1'b0;
      else if (flush && busy) disc_q <= 1'b1;
    end
  end

  assign rsp_ok = mem_rvalid & busy & ~disc_q & ~flush;
endmodule

// File: rtl/cq_irq.sv
module cq_irq
  import cq_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        set_done,
  input  logic        set_err,
  input  logic        sts_we,
  input  logic        ien_we,
  input  logic        ien_clr,
  input  logic [31:0] wdata,
  output logic [31:0] sts_word,
  output logic [31:0] ien_word,
  output logic        irq
);
  logic [31:0] set_v, kept;

  always_comb begin
    set_v = '0;
    set_v[0] = set_done;
    set_v[4] = set_err;
    kept = sts_we ? (sts_word & wdata) : sts_word;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sts_word <= '0;
      ien_word <= '0;
      irq      <= 1'b0;
    end else begin
      sts_word <= (kept | set_v) & IRQ_MASK;
      if (ien_clr) ien_word <= '0;
      else if (ien_we) ien_word <= wdata & IRQ_MASK;
      irq <= |(sts_word & ien_word);
    end
  end
endmodule

// File: rtl/cq_thread.sv
module cq_thread
  import cq_pkg::*;
#(
  parameter int          SHIFT  = 3,
  parameter logic [31:0] LIMIT  = 32'h100,
  parameter int          PRIO_W = 3,
  parameter int          RAW    = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           reg_we,
  input  logic [RAW-1:0] reg_addr,
  input  logic [31:0]    reg_wdata,
  output logic [31:0]    reg_rdata,
  output logic           mem_req,
  output logic [31:0]    mem_addr,
  input  logic           mem_rvalid,
  input  logic [63:0]    mem_rdata,
  input  logic           evt_in,
  output logic           irq
);
  localparam logic [31:0] INC = 32'(8 >> SHIFT);

  logic              wrst_q, en_q, susp_q, halt_q, wait_q;
  logic [31:0]       pc_q, end_q;
  logic [PRIO_W-1:0] prio_q;
  logic              busy, rsp_ok, issue, flush, done_hit, exec, wrst_done;
  logic              w_wrst, w_en, w_susp, w_ists, w_ien, w_pc, w_end, w_prio;
  logic [31:0]       sts_word, ien_word, target;
  kind_e             kind;

  assign w_wrst = reg_we && reg_addr == RAW'(OFF_WRST);
  assign w_en   = reg_we && reg_addr == RAW'(OFF_EN);
  assign w_susp = reg_we && reg_addr == RAW'(OFF_SUSP);
  assign w_ists = reg_we && reg_addr == RAW'(OFF_ISTS);
  assign w_ien  = reg_we && reg_addr == RAW'(OFF_IEN);
  assign w_pc   = reg_we && reg_addr == RAW'(OFF_PC);
  assign w_end  = reg_we && reg_addr == RAW'(OFF_END);
  assign w_prio = reg_we && reg_addr == RAW'(OFF_PRIO);

  assign wrst_done = wrst_q & ~busy;
  assign flush     = w_pc | wrst_done;
  assign issue     = en_q & ~susp_q & ~halt_q & ~wait_q & ~wrst_q & ~busy &
                     ~reg_we & (pc_q != end_q);
  assign done_hit  = en_q & ~halt_q & ~wait_q & ~wrst_q & ~busy & ~reg_we &
                     (pc_q == end_q);
  assign exec      = rsp_ok & en_q & ~wrst_q;

  cq_fetch #(.SHIFT(SHIFT)) u_fetch (
    .clk(clk), .rst(rst), .issue(issue), .pc(pc_q), .flush(flush),
    .mem_rvalid(mem_rvalid), .mem_req(mem_req), .mem_addr(mem_addr),
    .busy(busy), .rsp_ok(rsp_ok)
  );

  cq_decode #(.LIMIT(LIMIT)) u_dec (
    .instr(mem_rdata), .pc(pc_q), .kind(kind), .target(target)
  );

  cq_irq u_irq (
    .clk(clk), .rst(rst), .set_done(done_hit), .set_err(exec && kind == K_BAD),
    .sts_we(w_ists), .ien_we(w_ien), .ien_clr(wrst_done), .wdata(reg_wdata),
    .sts_word(sts_word), .ien_word(ien_word), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (rst || wrst_done) begin
      wrst_q <= 1'b0;
      en_q   <= 1'b0;
      susp_q <= 1'b0;
      halt_q <= 1'b0;
      wait_q <= 1'b0;
      pc_q   <= '0;
      end_q  <= '0;
      prio_q <= '0;
    end else begin
      if (w_wrst && reg_wdata[0]) wrst_q <= 1'b1;
      if (w_en) en_q <= reg_wdata[0];
      else if (done_hit) en_q <= 1'b0;
      if (w_susp) susp_q <= reg_wdata[0];
      if (w_end) end_q <= reg_wdata;
      if (w_prio) prio_q <= reg_wdata[PRIO_W-1:0];
      if (w_pc) begin
        pc_q   <= reg_wdata;
        halt_q <= 1'b0;
        wait_q <= 1'b0;
      end else if (exec) begin
        case (kind)
          K_NOP:  pc_q <= pc_q + INC;
          K_WAIT: if (evt_in) pc_q <= pc_q + INC; else wait_q <= 1'b1;
          K_JUMP: pc_q <= target;
          default: halt_q <= 1'b1;
        endcase
      end else if (wait_q && evt_in) begin
        wait_q <= 1'b0;
        pc_q   <= pc_q + INC;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else begin
      case (reg_addr)
        RAW'(OFF_WRST): reg_rdata <= {31'd0, wrst_q};
        RAW'(OFF_EN):   reg_rdata <= {31'd0, en_q};
        RAW'(OFF_SUSP): reg_rdata <= {31'd0, susp_q};
        RAW'(OFF_STAT): reg_rdata <= {30'd0, susp_q & ~busy, 1'b0};
        RAW'(OFF_ISTS): reg_rdata <= sts_word;
        RAW'(OFF_IEN):  reg_rdata <= ien_word;
        RAW'(OFF_PC):   reg_rdata <= pc_q;
        RAW'(OFF_END):  reg_rdata <= end_q;
        RAW'(OFF_WTOK): reg_rdata <= {wait_q, 31'd0};
        RAW'(OFF_PRIO): reg_rdata <= 32'(prio_q);
        default:        reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/cq_thread_chk.sv
module cq_thread_chk (
  input logic        clk,
  input logic        rst,
  input logic        mem_req,
  input logic        mem_rvalid,
  input logic        irq,
  input logic        en_q,
  input logic        susp_q,
  input logic        halt_q,
  input logic        wrst_q,
  input logic [31:0] pc_q,
  input logic [31:0] end_q,
  input logic [31:0] sts_word,
  input logic [31:0] ien_word
);
  logic [1:0] outstanding;

  always_ff @(posedge clk) begin
    if (rst) outstanding <= '0;
    else outstanding <= outstanding + {1'b0, mem_req} - {1'b0, mem_rvalid};
  end

  a_r3_single_outstanding: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> outstanding == 2'd0);

  a_r8_no_fetch_suspended: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !$past(susp_q));

  a_r7_halt_blocks_fetch: assert property (@(posedge clk) disable iff (rst)
    halt_q |=> !mem_req);

  a_r4_done_clears_enable: assert property (@(posedge clk) disable iff (rst)
    $rose(sts_word[0]) |-> !en_q);

  a_r2_wrst_clears_regs: assert property (@(posedge clk) disable iff (rst)
    $fell(wrst_q) |-> (pc_q == 32'd0 && end_q == 32'd0 && !en_q && !susp_q &&
                       ien_word == 32'd0));

  a_r11_irq_tracks: assert property (@(posedge clk) disable iff (rst)
    irq == $past(|(sts_word & ien_word)));
endmodule

bind cq_thread cq_thread_chk u_chk (
  .clk(clk), .rst(rst), .mem_req(mem_req), .mem_rvalid(mem_rvalid), .irq(irq),
  .en_q(en_q), .susp_q(susp_q), .halt_q(halt_q), .wrst_q(wrst_q),
  .pc_q(pc_q), .end_q(end_q), .sts_word(sts_word), .ien_word(ien_word)
);

// File: tb/tb_cq_thread.sv
module tb_cq_thread;
  localparam logic [7:0] A_WRST = 8'h00, A_EN = 8'h04, A_SUSP = 8'h08,
    A_STAT = 8'h0C, A_ISTS = 8'h10, A_IEN = 8'h14, A_PC = 8'h20,
    A_END = 8'h24, A_WTOK = 8'h30, A_PRIO = 8'h40;
  localparam logic [63:0] NOP = {8'h40, 56'd0};
  localparam int LAT = 3;

  logic        clk = 1'b0, rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        mem_req, mem_rvalid = 1'b0, evt_in = 1'b0, irq;
  logic [31:0] mem_addr;
  logic [63:0] mem_rdata = '0;

  logic [63:0] mem [64];
  int checks = 0, errors = 0;
  int fcnt = 0, ntgt = 0, fidx = 0;
  logic [31:0] tgt_addr = '0;
  logic [31:0] flog [16];
  int mcnt = 0;
  logic mpend = 1'b0;
  logic [31:0] maddr = '0;

  always #4 clk = ~clk;

  cq_thread dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .evt_in(evt_in), .irq(irq)
  );

  // memory model and fetch monitor, both on the falling edge
  always @(negedge clk) begin
    mem_rvalid <= 1'b0;
    if (mpend) begin
      if (mcnt <= 1) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= mem[maddr[8:3]];
        mpend      <= 1'b0;
      end
      mcnt <= mcnt - 1;
    end
    if (mem_req) begin
      mpend <= 1'b1;
      mcnt  <= LAT - 1;
      maddr <= mem_addr;
      fcnt  <= fcnt + 1;
      if (mem_addr == tgt_addr) ntgt <= ntgt + 1;
      if (fidx < 16) flog[fidx] <= mem_addr;
      fidx <= fidx + 1;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    @(posedge clk); @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_done();
    logic [31:0] v;
    for (int i = 0; i < 400; i++) begin
      rd(A_EN, v);
      if (v == 32'd0) break;
    end
  endtask

  task automatic run(input logic [31:0] pc, input logic [31:0] e);
    wr(A_END, e); wr(A_PC, pc); wr(A_IEN, 32'h13); wr(A_EN, 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v, p1;
    int f0;
    for (int i = 0; i < 64; i++) mem[i] = NOP;
    idle(3);
    @(negedge clk); rst = 1'b0;
    idle(1);

    // R1 reset state across the window
    rd(A_WRST, v); chk("R1 wrst", v, 0);
    rd(A_EN, v);   chk("R1 en", v, 0);
    rd(A_SUSP, v); chk("R1 susp", v, 0);
    rd(A_ISTS, v); chk("R1 ists", v, 0);
    rd(A_PC, v);   chk("R1 pc", v, 0);
    rd(A_END, v);  chk("R1 end", v, 0);
    rd(A_PRIO, v); chk("R1 prio", v, 0);
    chk("R1 mem_req", mem_req, 0);
    chk("R1 irq", irq, 0);

    // R3 R4 straight run of no-ops
    fidx = 0;
    run(0, 4); wait_done(); idle(2);
    rd(A_PC, v);   chk("R4 pc at end", v, 4);
    rd(A_ISTS, v); chk("R4 done flag", v, 1);
    chk("R4 irq", irq, 1);
    chk("R3 fetch count", fidx, 4);
    for (int k = 0; k < 4; k++) chk("R3 fetch addr", flog[k], 32'(k * 8));
    f0 = fcnt; idle(10); chk("R4 no fetch after done", fcnt, f0);

    // R11 write-zero-to-clear
    wr(A_ISTS, 32'hFFFF_FFFF); rd(A_ISTS, v); chk("R11 write ones keeps", v, 1);
    wr(A_ISTS, 32'hFFFF_FFFE); rd(A_ISTS, v); chk("R11 write zero clears", v, 0);
    idle(2); chk("R11 irq drops", irq, 0);

    // R5 absolute jump
    mem[10] = {32'h1000_0001, 32'd20}; mem[20] = NOP; fidx = 0;
    run(10, 21); wait_done();
    rd(A_PC, v); chk("R5 pc", v, 21);
    chk("R5 jump target fetched", flog[1], 32'd160);
    wr(A_ISTS, 0);

    // R6 relative jumps forward and backward
    mem[30] = {32'h1000_0000, 32'd5}; mem[35] = NOP; fidx = 0;
    run(30, 36); wait_done();
    rd(A_PC, v); chk("R6 forward pc", v, 36);
    chk("R6 forward fetch", flog[1], 32'd280);
    mem[38] = {32'h1000_0000, 32'hFFFF_FFFA}; mem[32] = NOP;
    run(38, 33); wait_done();
    rd(A_PC, v); chk("R6 backward pc", v, 33);
    wr(A_ISTS, 0);

    // R7 faults: unknown opcode, jump at the limit, jump just below it
    mem[45] = {8'h55, 56'd0}; fidx = 0;
    run(45, 50); idle(20);
    rd(A_ISTS, v); chk("R7 fault flag", v, 32'h10);
    rd(A_PC, v);   chk("R7 pc holds", v, 45);
    rd(A_EN, v);   chk("R7 enable stays", v, 1);
    chk("R7 single fetch", fidx, 1);
    chk("R7 irq", irq, 1);
    wr(A_ISTS, 0);
    mem[46] = {32'h1000_0001, 32'h100};
    wr(A_PC, 46); idle(20);
    rd(A_ISTS, v); chk("R7 limit fault", v, 32'h10);
    rd(A_PC, v);   chk("R7 limit pc", v, 46);
    wr(A_ISTS, 0);
    mem[47] = {32'h1000_0001, 32'hFF};
    wr(A_END, 32'h100); wr(A_PC, 47); wait_done();
    rd(A_PC, v);   chk("R7 below limit ok", v, 32'h100);
    rd(A_ISTS, v); chk("R7 below limit done", v, 1);

    // R2 warm reset
    wr(A_PRIO, 5); wr(A_END, 9); wr(A_PC, 3); wr(A_SUSP, 1); wr(A_EN, 1);
    wr(A_WRST, 1);
    rd(A_WRST, v); chk("R2 bit reads 1", v, 1);
    rd(A_WRST, v); chk("R2 self clears", v, 0);
    rd(A_PC, v);   chk("R2 pc", v, 0);
    rd(A_END, v);  chk("R2 end", v, 0);
    rd(A_PRIO, v); chk("R2 prio", v, 0);
    rd(A_IEN, v);  chk("R2 ien", v, 0);
    rd(A_SUSP, v); chk("R2 susp", v, 0);
    rd(A_EN, v);   chk("R2 en", v, 0);
    rd(A_ISTS, v); chk("R2 status kept", v, 1);
    wr(A_ISTS, 0);

    // R8 suspend handshake
    for (int i = 0; i < 20; i++) mem[i] = NOP;
    run(0, 20); wr(A_SUSP, 1);
    for (int i = 0; i < 50; i++) begin
      rd(A_STAT, v);
      if (v == 32'd2) break;
    end
    chk("R8 stopped flag", v, 2);
    rd(A_PC, p1); f0 = fcnt; idle(20);
    rd(A_PC, v); chk("R8 pc frozen", v, p1);
    chk("R8 no fetch", fcnt, f0);
    chk("R8 stopped early", 32'(p1 < 20), 1);
    wr(A_SUSP, 0); wait_done();
    rd(A_PC, v); chk("R8 resumed to end", v, 20);
    wr(A_ISTS, 0);

    // R9 same-value PC rewrite drops the in-flight response
    mem[50] = {32'h1000_0001, 32'd60}; mem[60] = NOP;
    tgt_addr = 32'd400; ntgt = 0;
    wr(A_END, 61); wr(A_PC, 50); wr(A_IEN, 32'h13); wr(A_EN, 1);
    idle(1); wr(A_PC, 50); wait_done();
    chk("R9 refetch count", ntgt, 2);
    rd(A_PC, v); chk("R9 pc", v, 61);
    wr(A_ISTS, 0);

    // R10 wait for event
    mem[5] = {8'h20, 56'd0}; mem[6] = NOP; evt_in = 1'b0;
    run(5, 7); idle(20);
    rd(A_WTOK, v); chk("R10 waiting flag", v, 32'h8000_0000);
    rd(A_PC, v);   chk("R10 pc held", v, 5);
    evt_in = 1'b1; wait_done();
    rd(A_PC, v);   chk("R10 released", v, 7);
    rd(A_WTOK, v); chk("R10 flag cleared", v, 0);
    evt_in = 1'b0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule